// File: doc/BRIEF.md
# Inclusive Outer-Cache Eviction Sequencer

This block runs the eviction side of block allocation in an outer cache that keeps inclusion over a single inner cache. When the outer cache misses and must allocate, it hands this sequencer three things: the requested (fill) block address, whether a victim way is being displaced, and that victim's address, dirty flag and contents. In inclusive mode, the sequencer first sends the inner cache a back-invalidate for the victim's block address. Both levels share one block size, so the address is passed through unchanged. The sequencer then waits for the inner cache's one-cycle answer.

If the inner copy was present and dirty, that data is newer than anything the outer cache holds. It goes to main memory as a block write, and the outer victim's write-back is dropped. Otherwise the outer victim is written back if it is dirty. The requested block is always read last. In non-inclusive mode the inner cache is never contacted. Allocation into a free (invalid) way needs no eviction at all, so it is only a read.

Main memory is reached through one request port with a valid/ready handshake that carries a write flag, a block address and block data. A done pulse marks the end of each allocation.

Top module: `incl_evict_ctrl`

## Requirements
- R1: After reset the block is idle: `alloc_ready` is 1, and `binv_valid`, `mem_req_valid` and `alloc_done` are 0.
- R2: In inclusive mode (`inclusive_mode`=1) with a victim (`victim_valid`=1), `binv_valid` is high for exactly one cycle, in the cycle after the allocation is accepted, with `binv_addr` equal to the victim address.
- R3: After a back-invalidate, no memory request is raised until the inner response (`binv_resp_valid`=1) has arrived, however many cycles it takes.
- R4: If the inner response reports `binv_resp_hit`=1 and `binv_resp_dirty`=1, a memory write (`mem_req_write`=1) of the response data to the victim address is issued.
- R5: When both the inner copy and the outer victim are dirty, only one write is issued, and it carries the inner data, never the outer victim data.
- R6: When the inner copy is absent or clean (or the mode is non-inclusive) and the outer victim is dirty, one memory write of the victim data to the victim address is issued.
- R7: Every allocation ends with exactly one memory read (`mem_req_write`=0) at the fill address, issued after any write. `alloc_done` pulses in the cycle after that read is accepted.
- R8: In non-inclusive mode (`inclusive_mode`=0), no back-invalidate is ever issued.
- R9: With no victim (`victim_valid`=0), no back-invalidate and no write occur, and only the fill read is issued.
- R10: While `mem_req_valid` is 1 and `mem_req_ready` is 0, the request's valid, write flag, address and data stay unchanged in the next cycle.
- R11: `alloc_ready` is 0 from acceptance until after `alloc_done`, and `alloc_valid` raised during that time is ignored: the fill address in use stays the one captured at acceptance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| inclusive_mode | input | 1 | 1 = inclusive (back-invalidate), 0 = non-inclusive |
| alloc_valid | input | 1 | Allocation request from the outer cache |
| alloc_ready | output | 1 | Sequencer idle, request accepted when both high |
| victim_valid | input | 1 | A valid victim is being evicted |
| victim_dirty | input | 1 | Outer victim is dirty |
| victim_addr | input | ADDR_W | Victim block address |
| victim_data | input | BLK_W | Outer victim block contents |
| fill_addr | input | ADDR_W | Requested block address |
| alloc_done | output | 1 | One-cycle pulse when the allocation is complete |
| binv_valid | output | 1 | Back-invalidate request to the inner cache |
| binv_addr | output | ADDR_W | Block address to invalidate |
| binv_resp_valid | input | 1 | One-cycle inner response |
| binv_resp_hit | input | 1 | Inner cache held the block |
| binv_resp_dirty | input | 1 | Inner copy was dirty |
| binv_resp_data | input | BLK_W | Inner block contents |
| mem_req_valid | output | 1 | Memory request valid |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_write | output | 1 | 1 = block write, 0 = block read |
| mem_req_addr | output | ADDR_W | Memory block address |
| mem_req_data | output | BLK_W | Write data |

## Verification
The back-invalidate appears one cycle after the accepting edge. Each memory request appears one cycle after the edge that ends the previous step: the inner response, or the acceptance of an earlier request. `alloc_done` follows the accepted read by one cycle. The bench drives every input on the falling edge and reads the outputs at that same falling edge. The response is therefore timed from the falling edge at which `binv_valid` was first seen, and the ready stalls are timed from the falling edge at which `mem_req_valid` was seen. Because the bench waits for each event instead of assuming a fixed latency, it can measure ordering (no request while waiting, read last) and hold-time stability under stalls cycle by cycle.

// File: rtl/incl_evict_pkg.sv
package incl_evict_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_BINV,
        ST_WAIT,
        ST_WR_IN,
        ST_WR_OUT,
        ST_FILL,
        ST_DONE
    } ev_state_e;

    typedef struct packed {
        logic incl;
        logic vic_valid;
        logic vic_dirty;
    } alloc_flags_t;

    // First step after an allocation is accepted.
    function automatic ev_state_e first_step(alloc_flags_t f);
        if (f.vic_valid && f.incl)           return ST_BINV;
        else if (f.vic_valid && f.vic_dirty) return ST_WR_OUT;
        else                                 return ST_FILL;
    endfunction

    // Step chosen once the inner cache has answered.
    function automatic ev_state_e after_resp(logic hit, logic dirty, logic outer_dirty);
        if (hit && dirty)     return ST_WR_IN;
        else if (outer_dirty) return ST_WR_OUT;
        else                  return ST_FILL;
    endfunction

endpackage

// File: rtl/incl_evict_seq.sv
module incl_evict_seq
    import incl_evict_pkg::*;
(
    input  logic         clk,
    input  logic         rst,
    input  logic         alloc_fire,
    input  alloc_flags_t live_flags,
    input  logic         outer_dirty_q,
    input  logic         resp_valid,
    input  logic         resp_hit,
    input  logic         resp_dirty,
    input  logic         mem_fire,
    output ev_state_e    state
);

    ev_state_e state_nx;

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:   if (alloc_fire) state_nx = first_step(live_flags);
            ST_BINV:   state_nx = ST_WAIT;
            ST_WAIT:   if (resp_valid) state_nx = after_resp(resp_hit, resp_dirty, outer_dirty_q);
            ST_WR_IN:  if (mem_fire) state_nx = ST_FILL;
            ST_WR_OUT: if (mem_fire) state_nx = ST_FILL;
            ST_FILL:   if (mem_fire) state_nx = ST_DONE;
            ST_DONE:   state_nx = ST_IDLE;
            default:   state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state <= ST_IDLE;
        else     state <= state_nx;
    end

    // R3: a response outside the waiting step must not move the sequence.
    assert_resp_only_in_wait_R3: assert property (@(posedge clk) disable iff (rst)
        (state == ST_BINV) |=> (state == ST_WAIT));

endmodule

// File: rtl/incl_evict_hold.sv
module incl_evict_hold
    import incl_evict_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int BLK_W  = 64
) (
    input  logic              clk,
    input  logic              rst,
    input  ev_state_e         state,
    input  logic              alloc_fire,
    input  logic              victim_dirty,
    input  logic [ADDR_W-1:0] victim_addr,
    input  logic [BLK_W-1:0]  victim_data,
    input  logic [ADDR_W-1:0] fill_addr,
    input  logic              resp_valid,
    input  logic              resp_hit,
    input  logic              resp_dirty,
    input  logic [BLK_W-1:0]  resp_data,
    output logic              vic_dirty_q,
    output logic [ADDR_W-1:0] vic_addr_q,
    output logic [BLK_W-1:0]  vic_data_q,
    output logic [ADDR_W-1:0] fill_addr_q,
    output logic [BLK_W-1:0]  inner_data_q
);

    logic take_inner;
    assign take_inner = (state == ST_WAIT) && resp_valid && resp_hit && resp_dirty;

    always_ff @(posedge clk) begin
        if (rst) begin
            vic_dirty_q  <= 1'b0;
            vic_addr_q   <= '0;
            vic_data_q   <= '0;
            fill_addr_q  <= '0;
            inner_data_q <= '0;
        end else begin
            if (alloc_fire) begin
                vic_dirty_q <= victim_dirty;
                vic_addr_q  <= victim_addr;
                vic_data_q  <= victim_data;
                fill_addr_q <= fill_addr;
            end
            if (take_inner) inner_data_q <= resp_data;
        end
    end

    // R11: captured fill address holds for the whole busy span.
    assert_fill_held_R11: assert property (@(posedge clk) disable iff (rst)
        (state != ST_IDLE && state != ST_DONE && $past(state) != ST_IDLE) |-> $stable(fill_addr_q));

endmodule

// File: rtl/incl_evict_memreq.sv
module incl_evict_memreq
    import incl_evict_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int BLK_W  = 64
) (
    input  ev_state_e         state,
    input  logic [ADDR_W-1:0] vic_addr_q,
    input  logic [BLK_W-1:0]  vic_data_q,
    input  logic [ADDR_W-1:0] fill_addr_q,
    input  logic [BLK_W-1:0]  inner_data_q,
    output logic              req_valid,
    output logic              req_write,
    output logic [ADDR_W-1:0] req_addr,
    output logic [BLK_W-1:0]  req_data
);

    always_comb begin
        req_valid = 1'b0;
        req_write = 1'b0;
        req_addr  = '0;
        req_data  = '0;
        unique case (state)
            ST_WR_IN: begin
                req_valid = 1'b1;
                req_write = 1'b1;
                req_addr  = vic_addr_q;
                req_data  = inner_data_q;
            end
            ST_WR_OUT: begin
                req_valid = 1'b1;
                req_write = 1'b1;
                req_addr  = vic_addr_q;
                req_data  = vic_data_q;
            end
            ST_FILL: begin
                req_valid = 1'b1;
                req_addr  = fill_addr_q;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/incl_evict_ctrl.sv
module incl_evict_ctrl
    import incl_evict_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int BLK_W  = 64
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              inclusive_mode,
    input  logic              alloc_valid,
    output logic              alloc_ready,
    input  logic              victim_valid,
    input  logic              victim_dirty,
    input  logic [ADDR_W-1:0] victim_addr,
    input  logic [BLK_W-1:0]  victim_data,
    input  logic [ADDR_W-1:0] fill_addr,
    output logic              alloc_done,
    output logic              binv_valid,
    output logic [ADDR_W-1:0] binv_addr,
    input  logic              binv_resp_valid,
    input  logic              binv_resp_hit,
    input  logic              binv_resp_dirty,
    input  logic [BLK_W-1:0]  binv_resp_data,
    output logic              mem_req_valid,
    input  logic              mem_req_ready,
    output logic              mem_req_write,
    output logic [ADDR_W-1:0] mem_req_addr,
    output logic [BLK_W-1:0]  mem_req_data
);

    ev_state_e         state;
    alloc_flags_t      live_flags;
    logic              alloc_fire;
    logic              mem_fire;
    logic              vic_dirty_q;
    logic [ADDR_W-1:0] vic_addr_q;
    logic [BLK_W-1:0]  vic_data_q;
    logic [ADDR_W-1:0] fill_addr_q;
    logic [BLK_W-1:0]  inner_data_q;

    assign live_flags = '{incl: inclusive_mode, vic_valid: victim_valid, vic_dirty: victim_dirty};
    assign alloc_ready = (state == ST_IDLE);
    assign alloc_fire  = alloc_valid && alloc_ready;
    assign mem_fire    = mem_req_valid && mem_req_ready;
    assign binv_valid  = (state == ST_BINV);
    assign binv_addr   = vic_addr_q;
    assign alloc_done  = (state == ST_DONE);

    incl_evict_seq u_seq (
        .clk           (clk),
        .rst           (rst),
        .alloc_fire    (alloc_fire),
        .live_flags    (live_flags),
        .outer_dirty_q (vic_dirty_q),
        .resp_valid    (binv_resp_valid),
        .resp_hit      (binv_resp_hit),
        .resp_dirty    (binv_resp_dirty),
        .mem_fire      (mem_fire),
        .state         (state)
    );

    incl_evict_hold #(.ADDR_W(ADDR_W), .BLK_W(BLK_W)) u_hold (
        .clk          (clk),
        .rst          (rst),
        .state        (state),
        .alloc_fire   (alloc_fire),
        .victim_dirty (victim_dirty),
        .victim_addr  (victim_addr),
        .victim_data  (victim_data),
        .fill_addr    (fill_addr),
        .resp_valid   (binv_resp_valid),
        .resp_hit     (binv_resp_hit),
        .resp_dirty   (binv_resp_dirty),
        .resp_data    (binv_resp_data),
        .vic_dirty_q  (vic_dirty_q),
        .vic_addr_q   (vic_addr_q),
        .vic_data_q   (vic_data_q),
        .fill_addr_q  (fill_addr_q),
        .inner_data_q (inner_data_q)
    );

    incl_evict_memreq #(.ADDR_W(ADDR_W), .BLK_W(BLK_W)) u_memreq (
        .state        (state),
        .vic_addr_q   (vic_addr_q),
        .vic_data_q   (vic_data_q),
        .fill_addr_q  (fill_addr_q),
        .inner_data_q (inner_data_q),
        .req_valid    (mem_req_valid),
        .req_write    (mem_req_write),
        .req_addr     (mem_req_addr),
        .req_data     (mem_req_data)
    );

    assert_binv_single_R2: assert property (@(posedge clk) disable iff (rst)
        binv_valid |=> !binv_valid);

    assert_no_mem_after_binv_R3: assert property (@(posedge clk) disable iff (rst)
        binv_valid |=> !mem_req_valid);

    assert_done_after_read_R7: assert property (@(posedge clk) disable iff (rst)
        alloc_done |-> $past(mem_req_valid && mem_req_ready && !mem_req_write));

    assert_noninc_no_binv_R8: assert property (@(posedge clk) disable iff (rst)
        (alloc_valid && alloc_ready && !inclusive_mode) |=> !binv_valid);

    assert_novictim_read_only_R9: assert property (@(posedge clk) disable iff (rst)
        (alloc_valid && alloc_ready && !victim_valid) |=> (mem_req_valid && !mem_req_write && !binv_valid));

    assert_req_stable_R10: assert property (@(posedge clk) disable iff (rst)
        (mem_req_valid && !mem_req_ready) |=>
            (mem_req_valid && $stable(mem_req_write) && $stable(mem_req_addr) && $stable(mem_req_data)));

    assert_busy_R11: assert property (@(posedge clk) disable iff (rst)
        (alloc_valid && alloc_ready) |=> !alloc_ready);

endmodule

// File: tb/incl_evict_ctrl_tb_top.sv
module incl_evict_ctrl_tb_top;

    localparam int ADDR_W = 32;
    localparam int BLK_W  = 64;
    localparam int NVEC   = 11;

    // [10]incl [9]vic_valid [8]vic_dirty [7]resp_hit [6]resp_dirty
    // [5:4]resp delay [3:2]ready stall cycles [1]poke while busy [0]spare
    localparam logic [10:0] VECS [0:NVEC-1] = '{
        11'b111_00_00_00_0_0,
        11'b111_00_00_00_0_0 | 11'b001_00_00_00_0_0,
        11'b110_11_00_00_0_0,
        11'b111_11_10_00_0_0,
        11'b111_10_01_00_0_0,
        11'b011_00_00_00_0_0,
        11'b010_00_00_00_0_0,
        11'b100_00_00_00_0_0,
        11'b111_11_00_10_0_0,
        11'b111_00_11_01_1_0,
        11'b011_00_00_11_1_0
    };

    logic              clk = 1'b0;
    logic              rst;
    logic              inclusive_mode, alloc_valid, alloc_ready;
    logic              victim_valid, victim_dirty;
    logic [ADDR_W-1:0] victim_addr, fill_addr, binv_addr, mem_req_addr;
    logic [BLK_W-1:0]  victim_data, binv_resp_data, mem_req_data;
    logic              alloc_done, binv_valid;
    logic              binv_resp_valid, binv_resp_hit, binv_resp_dirty;
    logic              mem_req_valid, mem_req_ready, mem_req_write;

    int n_checks = 0;
    int n_errors = 0;

    always #10 clk = ~clk;

    incl_evict_ctrl #(.ADDR_W(ADDR_W), .BLK_W(BLK_W)) dut_i (
        .clk(clk), .rst(rst), .inclusive_mode(inclusive_mode),
        .alloc_valid(alloc_valid), .alloc_ready(alloc_ready),
        .victim_valid(victim_valid), .victim_dirty(victim_dirty),
        .victim_addr(victim_addr), .victim_data(victim_data), .fill_addr(fill_addr),
        .alloc_done(alloc_done), .binv_valid(binv_valid), .binv_addr(binv_addr),
        .binv_resp_valid(binv_resp_valid), .binv_resp_hit(binv_resp_hit),
        .binv_resp_dirty(binv_resp_dirty), .binv_resp_data(binv_resp_data),
        .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
        .mem_req_write(mem_req_write), .mem_req_addr(mem_req_addr),
        .mem_req_data(mem_req_data)
    );

    task automatic chk(input logic ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic run_vec(input int idx, input logic [10:0] v);
        logic incl, vv, vd, hit, rdt, poke;
        int   dly, stall;
        logic exp_binv, exp_inner, exp_outer;
        logic [ADDR_W-1:0] vaddr, faddr, last_binv_addr, wr_addr, rd_addr, p_addr;
        logic [BLK_W-1:0]  vdata, idata, wr_data, p_data;
        logic p_write;
        int binv_n, wr_n, rd_n, resp_cd, stall_cnt;
        logic waiting, mem_in_wait, order_bad, stable_bad, done;
        incl = v[10]; vv = v[9]; vd = v[8]; hit = v[7]; rdt = v[6];
        dly = int'(v[5:4]); stall = int'(v[3:2]); poke = v[1];
        exp_binv  = incl && vv;
        exp_inner = exp_binv && hit && rdt;
        exp_outer = vv && vd && !exp_inner;
        vaddr = 32'h0001_0000 + idx;
        faddr = 32'h0002_0000 + idx;
        vdata = 64'hAAAA_0000_0000_0000 | 64'(idx);
        idata = 64'h5555_0000_0000_0000 | 64'(idx);
        @(negedge clk);
        inclusive_mode = incl; victim_valid = vv; victim_dirty = vd;
        victim_addr = vaddr; victim_data = vdata; fill_addr = faddr;
        alloc_valid = 1'b1;
        @(negedge clk);
        alloc_valid = 1'b0;
        binv_n = 0; wr_n = 0; rd_n = 0; resp_cd = -1; stall_cnt = 0;
        waiting = 0; mem_in_wait = 0; order_bad = 0; stable_bad = 0; done = 0;
        last_binv_addr = '0; wr_addr = '0; rd_addr = '0; wr_data = '0;
        p_addr = '0; p_data = '0; p_write = 1'b0;
        for (int cyc = 0; cyc < 40 && !done; cyc++) begin
            binv_resp_valid = 1'b0;
            if (waiting && mem_req_valid) mem_in_wait = 1;
            if (resp_cd == 0) begin
                binv_resp_valid = 1'b1; binv_resp_hit = hit;
                binv_resp_dirty = rdt; binv_resp_data = idata;
                resp_cd = -1; waiting = 0;
            end else if (resp_cd > 0) resp_cd--;
            if (binv_valid) begin
                binv_n++; last_binv_addr = binv_addr; waiting = 1; resp_cd = dly;
            end
            mem_req_ready = 1'b1;
            if (mem_req_valid) begin
                if (stall_cnt > 0 && (mem_req_addr != p_addr || mem_req_data != p_data ||
                                      mem_req_write != p_write)) stable_bad = 1;
                p_addr = mem_req_addr; p_data = mem_req_data; p_write = mem_req_write;
                if (stall_cnt < stall) begin
                    mem_req_ready = 1'b0; stall_cnt++;
                end else begin
                    stall_cnt = 0;
                    if (mem_req_write) begin
                        wr_n++; wr_addr = mem_req_addr; wr_data = mem_req_data;
                        if (rd_n > 0) order_bad = 1;
                    end else begin
                        rd_n++; rd_addr = mem_req_addr;
                    end
                end
            end
            if (poke && cyc == 1) begin
                alloc_valid = 1'b1; fill_addr = 32'hDEAD_0000 + idx;
                chk(alloc_ready == 1'b0, "R11 busy", 64'(alloc_ready), 64'd0);
            end else alloc_valid = 1'b0;
            if (alloc_done) done = 1;
            @(negedge clk);
        end
        binv_resp_valid = 1'b0;
        alloc_valid = 1'b0;
        chk(done, "R7 done pulse", 64'(done), 64'd1);
        chk(binv_n == int'(exp_binv), exp_binv ? "R2 binv count" : (incl ? "R9 binv count" : "R8 binv count"),
            64'(binv_n), 64'(exp_binv));
        if (exp_binv) chk(last_binv_addr == vaddr, "R2 binv addr", 64'(last_binv_addr), 64'(vaddr));
        chk(!mem_in_wait, "R3 mem while waiting", 64'(mem_in_wait), 64'd0);
        chk(wr_n == int'(exp_inner || exp_outer), exp_inner && vd ? "R5 write count" : "R6 write count",
            64'(wr_n), 64'(exp_inner || exp_outer));
        if (exp_inner) begin
            chk(wr_data == idata, vd ? "R5 inner data wins" : "R4 inner data", wr_data, idata);
            chk(wr_addr == vaddr, "R4 write addr", 64'(wr_addr), 64'(vaddr));
        end else if (exp_outer) begin
            chk(wr_data == vdata, "R6 outer data", wr_data, vdata);
            chk(wr_addr == vaddr, "R6 write addr", 64'(wr_addr), 64'(vaddr));
        end
        chk(rd_n == 1, "R7 read count", 64'(rd_n), 64'd1);
        chk(rd_addr == faddr, poke ? "R11 fill addr kept" : "R7 fill addr", 64'(rd_addr), 64'(faddr));
        chk(!order_bad, "R7 read last", 64'(order_bad), 64'd0);
        if (stall > 0) chk(!stable_bad, "R10 stable under stall", 64'(stable_bad), 64'd0);
        chk(alloc_ready == 1'b1, "R11 ready after done", 64'(alloc_ready), 64'd1);
        if (poke) begin
            @(negedge clk);
            chk(!binv_valid && !mem_req_valid && alloc_ready, "R11 poke ignored",
                {62'd0, binv_valid, mem_req_valid}, 64'd0);
        end
    endtask

    initial begin
        int cycles = 0;
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 20000) begin
                n_checks++; n_errors++;
                $display("FAIL watchdog expired");
                $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
                $finish;
            end
        end
    end

    initial begin
        rst = 1'b1; inclusive_mode = 1'b1; alloc_valid = 1'b0;
        victim_valid = 1'b0; victim_dirty = 1'b0; victim_addr = '0; victim_data = '0;
        fill_addr = '0; binv_resp_valid = 1'b0; binv_resp_hit = 1'b0;
        binv_resp_dirty = 1'b0; binv_resp_data = '0; mem_req_ready = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: reset state
        chk(alloc_ready == 1'b1, "R1 ready", 64'(alloc_ready), 64'd1);
        chk(!binv_valid && !mem_req_valid && !alloc_done, "R1 outputs idle",
            {61'd0, binv_valid, mem_req_valid, alloc_done}, 64'd0);
        for (int i = 0; i < NVEC; i++) run_vec(i, VECS[i]);
        // directed: reset in the middle of an allocation returns to idle (R1)
        @(negedge clk);
        inclusive_mode = 1'b1; victim_valid = 1'b1; victim_dirty = 1'b1; alloc_valid = 1'b1;
        @(negedge clk);
        alloc_valid = 1'b0; rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        chk(alloc_ready && !binv_valid && !mem_req_valid, "R1 mid-run reset",
            {61'd0, alloc_ready, binv_valid, mem_req_valid}, 64'h4);
        // directed: back-to-back run after the reset still works
        run_vec(20, 11'b111_11_00_00_0_0);
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

endmodule